// File: doc/BRIEF.md
# Serial Flash Command Front-End

This block is the command decoder and status-register keeper that sits behind the serial pins of a flash memory. It acts only as a slave. A system clock oversamples the serial clock, the active-low select, the data-in line, an active-low pause input and an active-low write-protect input. It follows SPI mode 0: input bits are taken on rising serial-clock edges and output bits change on falling edges. The output has a data bit and a separate enable, so a pad can tri-state it.

After select falls, the first eight bits form a command. Four commands are known: set and clear the write-enable latch, stream out the status byte, and replace the writable status bits. Any other command locks the transfer until the next select. A status replacement takes effect only when select rises. At that moment the block starts the internal nonvolatile write by raising a one-cycle strobe that carries the new byte. The array, erase, program and nonvolatile timing belong to other blocks.

A pause input can freeze a transfer in the middle. A write-protect pin, active only while the protect-enable status bit is set, can veto a status replacement at any point before it commits.

Top module: `sflash_cmd_fe`

## Requirements
- R1: After reset, and whenever select is high, `so_oe` is 0. While select is high, activity on `sck` and `si` changes no state. After reset the status reads 0x00.
- R2: Bits travel most significant first. `si` is taken on rising `sck`. `so` changes after falling `sck`, so it is valid while `sck` is low before the next rise.
- R3: Command 0x06 sets the write-enable latch (status bit 1) and command 0x04 clears it. Each takes effect when select rises, and only if exactly 8 clocks were given.
- R4: Command 0x05 drives the status byte on `so` from the falling edge after the command onward. It repeats the byte for as long as clocks continue. Status layout: bit 7 protect-enable, bits 3 and 2 general writable bits, bit 1 write-enable latch, bit 0 busy.
- R5: Command 0x01 followed by one data byte commits when select rises, provided the latch is set. Only bits 7, 3 and 2 take the new value. The latch clears. `nv_wr_start` pulses for exactly one cycle, with the committed byte on `nv_wr_data`.
- R6: A status write commits only with exactly 16 clocks and a set latch. A set or clear command with a clock count other than 8 has no effect.
- R7: An unknown command keeps `so_oe` at 0 and makes every later bit be ignored, until the next falling edge of select.
- R8: Pulling `hold_n` low while `sck` is low pauses the transfer, and `so_oe` drops. Clocks and data during the pause are ignored. Raising `hold_n` while `sck` is low resumes at the same bit position.
- R9: With protect-enable set, `wp_n` low at any time while a status write is being shifted in aborts that write. A `wp_n` pulse that ends before select rises still aborts it. The latch stays set after an abort.
- R10: With protect-enable clear, `wp_n` has no effect on status writes.
- R11: Once select has risen and the write has committed, a later change on `wp_n` does not undo it.
- R12: Status bit 0 follows the `nv_busy` input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Serial clock from the master |
| cs_n | input | 1 | Active-low select |
| si | input | 1 | Serial data in |
| hold_n | input | 1 | Active-low pause request |
| wp_n | input | 1 | Active-low write-protect |
| nv_busy | input | 1 | Internal nonvolatile write in progress |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Output enable for the `so` pad |
| nv_wr_start | output | 1 | One-cycle strobe that starts the internal write |
| nv_wr_data | output | 8 | Status byte that goes with the strobe |

## Verification
The bench builds the block with its default parameters: two synchronizer stages, the four standard command codes and a writable mask of 0x8C. It holds each serial-clock phase for eight system clocks, which is more than the three to four cycles the synchronizers and edge detectors take. That margin lets the output be sampled at a fixed point in every low phase. Writing 0xFF through the mask of 0x8C shows at once which bits were filtered. The mask also puts protect-enable among the writable bits, so both the gated and the ungated write-protect cases can be reached with plain status writes.

// File: rtl/sflash_fe_pkg.sv
package sflash_fe_pkg;

   localparam int unsigned BYTE_W = 8;

   typedef enum logic [1:0] {
      PH_IDLE,
      PH_OPCODE,
      PH_BODY,
      PH_LOCKED
   } phase_e;

   typedef enum logic [2:0] {
      CMD_NONE,
      CMD_WREN,
      CMD_WRDI,
      CMD_RDSR,
      CMD_WRSR
   } cmd_e;

endpackage

// File: rtl/sflash_fe_sync.sv
module sflash_fe_sync #(
   parameter int                STAGES  = 2,
   parameter int                WIDTH   = 5,
   parameter logic [WIDTH-1:0]  RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   generate
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_chain
         logic [WIDTH-1:0] chain [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < STAGES; i++) chain[i] <= RST_VAL;
            end else begin
               chain[0] <= d;
               for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
            end
         end
         assign q = chain[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/sflash_fe_link.sv
module sflash_fe_link
   import sflash_fe_pkg::*;
#(
   parameter logic [7:0] OP_WREN   = 8'h06,
   parameter logic [7:0] OP_WRDI   = 8'h04,
   parameter logic [7:0] OP_RDSR   = 8'h05,
   parameter logic [7:0] OP_WRSR   = 8'h01,
   parameter int         BIT_LIMIT = 17,
   parameter int         CNT_W     = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sck_s,
   input  logic             sel_s,
   input  logic             si_s,
   input  logic             hold_n_s,
   input  logic [7:0]       stat_byte,
   output logic             so,
   output logic             so_oe,
   output logic             hold_act,
   output logic [CNT_W-1:0] bit_cnt,
   output logic             cmd_end,
   output cmd_e             cmd_kind,
   output logic [7:0]       wr_byte,
   output logic             in_wrsr
);

   localparam logic [CNT_W-1:0] OPC_LAST  = CNT_W'(BYTE_W - 1);
   localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(2 * BYTE_W - 1);
   localparam logic [CNT_W-1:0] CNT_TOP   = CNT_W'(BIT_LIMIT);

   function automatic cmd_e decode(input logic [7:0] b);
      if (b == OP_WREN)      return CMD_WREN;
      else if (b == OP_WRDI) return CMD_WRDI;
      else if (b == OP_RDSR) return CMD_RDSR;
      else if (b == OP_WRSR) return CMD_WRSR;
      else                   return CMD_NONE;
   endfunction

   logic       sck_q, sel_q;
   logic       sck_rise, sck_fall, sel_start, sel_stop, live;
   phase_e     phase;
   cmd_e       cmd;
   logic [7:0] shreg, nxt_byte, snap;
   logic [2:0] rd_idx;
   logic       so_q, out_on;
   logic       reading;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_q <= 1'b0;
         sel_q <= 1'b0;
      end else begin
         sck_q <= sck_s;
         sel_q <= sel_s;
      end
   end

   assign sck_rise  = sck_s & ~sck_q;
   assign sck_fall  = ~sck_s & sck_q;
   assign sel_start = sel_s & ~sel_q;
   assign sel_stop  = ~sel_s & sel_q;
   assign live      = sel_s & ~hold_act;
   assign nxt_byte  = {shreg[6:0], si_s};
   assign reading   = (phase == PH_BODY) && (cmd == CMD_RDSR);

   // pause tracking: entry and exit only while the serial clock is low
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              hold_act <= 1'b0;
      else if (!sel_s)                         hold_act <= 1'b0;
      else if (!hold_act && !hold_n_s && !sck_s) hold_act <= 1'b1;
      else if (hold_act && hold_n_s && !sck_s)   hold_act <= 1'b0;
   end

   // command phase tracking and input shifting
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase   <= PH_IDLE;
         cmd     <= CMD_NONE;
         bit_cnt <= '0;
         shreg   <= '0;
         wr_byte <= '0;
         cmd_end <= 1'b0;
      end else begin
         cmd_end <= 1'b0;
         if (sel_start) begin
            phase   <= PH_OPCODE;
            cmd     <= CMD_NONE;
            bit_cnt <= '0;
         end else if (sel_stop) begin
            phase   <= PH_IDLE;
            cmd_end <= (phase == PH_BODY);
         end else if (live && sck_rise &&
                      (phase == PH_OPCODE || phase == PH_BODY)) begin
            shreg <= nxt_byte;
            if (bit_cnt != CNT_TOP) bit_cnt <= bit_cnt + 1'b1;
            if (phase == PH_OPCODE && bit_cnt == OPC_LAST) begin
               cmd   <= decode(nxt_byte);
               phase <= (decode(nxt_byte) == CMD_NONE) ? PH_LOCKED : PH_BODY;
            end
            if (phase == PH_BODY && cmd == CMD_WRSR && bit_cnt == DATA_LAST)
               wr_byte <= nxt_byte;
         end
      end
   end

   // status streaming on falling serial clock
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_idx <= '0;
         snap   <= '0;
         so_q   <= 1'b0;
         out_on <= 1'b0;
      end else if (sel_start) begin
         rd_idx <= '0;
         out_on <= 1'b0;
      end else if (live && sck_fall && reading) begin
         if (rd_idx == 3'd0) begin
            snap <= stat_byte;
            so_q <= stat_byte[7];
         end else begin
            so_q <= snap[3'd7 - rd_idx];
         end
         rd_idx <= rd_idx + 1'b1;
         out_on <= 1'b1;
      end
   end

   assign so_oe    = sel_s & reading & out_on & ~hold_act;
   assign so       = so_q & so_oe;
   assign cmd_kind = cmd;
   assign in_wrsr  = (phase == PH_BODY) && (cmd == CMD_WRSR);

endmodule

// File: rtl/sflash_fe_status.sv
module sflash_fe_status
   import sflash_fe_pkg::*;
#(
   parameter logic [7:0] WR_MASK   = 8'h8C,
   parameter int         WEL_BIT   = 1,
   parameter int         BUSY_BIT  = 0,
   parameter int         WPEN_BIT  = 7,
   parameter logic [7:0] STAT_INIT = 8'h00,
   parameter int         CNT_W     = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_end,
   input  cmd_e             cmd_kind,
   input  logic [CNT_W-1:0] bit_cnt,
   input  logic [7:0]       wr_byte,
   input  logic             in_wrsr,
   input  logic             wp_n_s,
   input  logic             nv_busy,
   output logic [7:0]       stat_byte,
   output logic             wel,
   output logic             wpen,
   output logic             nv_wr_start,
   output logic [7:0]       nv_wr_data
);

   localparam logic [CNT_W-1:0] ONE_BYTE  = CNT_W'(BYTE_W);
   localparam logic [CNT_W-1:0] TWO_BYTES = CNT_W'(2 * BYTE_W);

   logic [7:0] keep_q, merged;
   logic       wel_q, abort_q, commit;

   assign wpen   = keep_q[WPEN_BIT];
   assign merged = (keep_q & ~WR_MASK) | (wr_byte & WR_MASK);
   assign commit = cmd_end && (cmd_kind == CMD_WRSR) && (bit_cnt == TWO_BYTES)
                   && wel_q && !abort_q;

   // write-protect veto, latched for the whole status-write transfer
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          abort_q <= 1'b0;
      else if (cmd_end)                    abort_q <= 1'b0;
      else if (in_wrsr && !wp_n_s && wpen) abort_q <= 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         keep_q      <= STAT_INIT & WR_MASK;
         wel_q       <= 1'b0;
         nv_wr_start <= 1'b0;
         nv_wr_data  <= '0;
      end else begin
         nv_wr_start <= 1'b0;
         if (commit) begin
            keep_q      <= merged;
            wel_q       <= 1'b0;
            nv_wr_start <= 1'b1;
            nv_wr_data  <= merged;
         end else if (cmd_end && bit_cnt == ONE_BYTE) begin
            if (cmd_kind == CMD_WREN)      wel_q <= 1'b1;
            else if (cmd_kind == CMD_WRDI) wel_q <= 1'b0;
         end
      end
   end

   assign wel = wel_q;

   generate
      for (genvar b = 0; b < 8; b++) begin : g_bit
         if (b == WEL_BIT) begin : g_wel
            assign stat_byte[b] = wel_q;
         end else if (b == BUSY_BIT) begin : g_busy
            assign stat_byte[b] = nv_busy;
         end else if (WR_MASK[b]) begin : g_keep
            assign stat_byte[b] = keep_q[b];
         end else begin : g_zero
            assign stat_byte[b] = 1'b0;
         end
      end
   endgenerate

endmodule

// File: rtl/sflash_cmd_fe.sv
module sflash_cmd_fe
   import sflash_fe_pkg::*;
#(
   parameter int         SYNC_STAGES = 2,
   parameter logic [7:0] OP_WREN     = 8'h06,
   parameter logic [7:0] OP_WRDI     = 8'h04,
   parameter logic [7:0] OP_RDSR     = 8'h05,
   parameter logic [7:0] OP_WRSR     = 8'h01,
   parameter logic [7:0] WR_MASK     = 8'h8C,
   parameter int         WEL_BIT     = 1,
   parameter int         BUSY_BIT    = 0,
   parameter int         WPEN_BIT    = 7,
   parameter logic [7:0] STAT_INIT   = 8'h00
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sck,
   input  logic       cs_n,
   input  logic       si,
   input  logic       hold_n,
   input  logic       wp_n,
   input  logic       nv_busy,
   output logic       so,
   output logic       so_oe,
   output logic       nv_wr_start,
   output logic [7:0] nv_wr_data
);

   localparam int BIT_LIMIT = 2 * BYTE_W + 1;
   localparam int CNT_W     = $clog2(BIT_LIMIT + 1);

   generate
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("SYNC_STAGES must lie in 0..4");
      end
      if (WEL_BIT < 0 || WEL_BIT > 7 || BUSY_BIT < 0 || BUSY_BIT > 7 ||
          WPEN_BIT < 0 || WPEN_BIT > 7) begin : g_bad_index
         $error("status bit positions must lie in 0..7");
      end else if (WEL_BIT == BUSY_BIT || WR_MASK[WEL_BIT] ||
                   WR_MASK[BUSY_BIT] || !WR_MASK[WPEN_BIT]) begin : g_bad_mask
         $error("writable mask must cover protect-enable and exclude latch and busy");
      end
      if (OP_WREN == OP_WRDI || OP_WREN == OP_RDSR || OP_WREN == OP_WRSR ||
          OP_WRDI == OP_RDSR || OP_WRDI == OP_WRSR || OP_RDSR == OP_WRSR) begin : g_bad_op
         $error("command codes must be distinct");
      end
   endgenerate

   logic [4:0]       pins_s;
   logic             sck_s, sel_s, si_s, hold_n_s, wp_n_s;
   logic [7:0]       stat_byte, wr_byte;
   logic             hold_act, cmd_end, in_wrsr, wel, wpen;
   logic [CNT_W-1:0] bit_cnt;
   cmd_e             cmd_kind;

   sflash_fe_sync #(
      .STAGES  (SYNC_STAGES),
      .WIDTH   (5),
      .RST_VAL (5'b01011)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({sck, cs_n, si, hold_n, wp_n}),
      .q     (pins_s)
   );

   assign sck_s    = pins_s[4];
   assign sel_s    = ~pins_s[3];
   assign si_s     = pins_s[2];
   assign hold_n_s = pins_s[1];
   assign wp_n_s   = pins_s[0];

   sflash_fe_link #(
      .OP_WREN   (OP_WREN),
      .OP_WRDI   (OP_WRDI),
      .OP_RDSR   (OP_RDSR),
      .OP_WRSR   (OP_WRSR),
      .BIT_LIMIT (BIT_LIMIT),
      .CNT_W     (CNT_W)
   ) u_link (
      .clk       (clk),
      .rst_n     (rst_n),
      .sck_s     (sck_s),
      .sel_s     (sel_s),
      .si_s      (si_s),
      .hold_n_s  (hold_n_s),
      .stat_byte (stat_byte),
      .so        (so),
      .so_oe     (so_oe),
      .hold_act  (hold_act),
      .bit_cnt   (bit_cnt),
      .cmd_end   (cmd_end),
      .cmd_kind  (cmd_kind),
      .wr_byte   (wr_byte),
      .in_wrsr   (in_wrsr)
   );

   sflash_fe_status #(
      .WR_MASK   (WR_MASK),
      .WEL_BIT   (WEL_BIT),
      .BUSY_BIT  (BUSY_BIT),
      .WPEN_BIT  (WPEN_BIT),
      .STAT_INIT (STAT_INIT),
      .CNT_W     (CNT_W)
   ) u_status (
      .clk         (clk),
      .rst_n       (rst_n),
      .cmd_end     (cmd_end),
      .cmd_kind    (cmd_kind),
      .bit_cnt     (bit_cnt),
      .wr_byte     (wr_byte),
      .in_wrsr     (in_wrsr),
      .wp_n_s      (wp_n_s),
      .nv_busy     (nv_busy),
      .stat_byte   (stat_byte),
      .wel         (wel),
      .wpen        (wpen),
      .nv_wr_start (nv_wr_start),
      .nv_wr_data  (nv_wr_data)
   );

endmodule

// File: rtl/sflash_cmd_fe_chk.sv
module sflash_cmd_fe_chk #(
   parameter int CNT_W = 5
) (
   input logic             clk,
   input logic             rst_n,
   input logic             sel_s,
   input logic             so_oe,
   input logic             hold_act,
   input logic [CNT_W-1:0] bit_cnt,
   input logic             nv_wr_start,
   input logic             wel,
   input logic             in_wrsr,
   input logic             wp_n_s,
   input logic             wpen
);

   AST_OE_NEEDS_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
      !sel_s |=> !so_oe); // R1

   AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      nv_wr_start |=> !nv_wr_start); // R5

   AST_START_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
      nv_wr_start |-> $past(wel)); // R5

   AST_WEL_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      nv_wr_start |-> !wel); // R5

   AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
      (hold_act && $past(hold_act)) |-> $stable(bit_cnt)); // R8

   AST_WP_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      (in_wrsr && !wp_n_s && wpen) |=> !nv_wr_start); // R9

endmodule

bind sflash_cmd_fe sflash_cmd_fe_chk #(.CNT_W(CNT_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .sel_s       (sel_s),
   .so_oe       (so_oe),
   .hold_act    (hold_act),
   .bit_cnt     (bit_cnt),
   .nv_wr_start (nv_wr_start),
   .wel         (wel),
   .in_wrsr     (in_wrsr),
   .wp_n_s      (wp_n_s),
   .wpen        (wpen)
);

// File: tb/sflash_cmd_fe_bench.sv
module sflash_cmd_fe_bench;

   localparam int HALF = 8;
   localparam int WD   = 150000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sck = 1'b0, cs_n = 1'b1, si = 1'b0, hold_n = 1'b1, wp_n = 1'b1;
   logic       nv_busy = 1'b0;
   logic       so, so_oe, nv_wr_start;
   logic [7:0] nv_wr_data;

   int         nchk = 0, nfail = 0, starts = 0;
   logic [7:0] last_wr = '0;
   bit         done = 1'b0;

   always #5 clk = ~clk;

   sflash_cmd_fe u_sflash_cmd_fe (
      .clk (clk), .rst_n (rst_n), .sck (sck), .cs_n (cs_n), .si (si),
      .hold_n (hold_n), .wp_n (wp_n), .nv_busy (nv_busy), .so (so),
      .so_oe (so_oe), .nv_wr_start (nv_wr_start), .nv_wr_data (nv_wr_data)
   );

   always @(negedge clk) if (rst_n && nv_wr_start) begin
      starts++;
      last_wr = nv_wr_data;
   end

   task automatic wait_clks(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(input bit ok, input string tag, input logic [31:0] act,
                        input logic [31:0] exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic sel();
      cs_n = 1'b0;
      wait_clks(HALF);
   endtask

   task automatic desel();
      wait_clks(HALF);
      cs_n = 1'b1;
      wait_clks(4 * HALF);
   endtask

   task automatic shift(input int n, input logic [23:0] tx, output logic [23:0] rx,
                        output logic oe_all, output logic oe_any);
      rx = '0; oe_all = 1'b1; oe_any = 1'b0;
      for (int i = n - 1; i >= 0; i--) begin
         si = tx[i];
         wait_clks(HALF);
         rx[i]  = so;
         oe_all = oe_all & so_oe;
         oe_any = oe_any | so_oe;
         sck = 1'b1;
         wait_clks(HALF);
         sck = 1'b0;
      end
   endtask

   task automatic send(input int n, input logic [23:0] tx);
      logic [23:0] rx; logic a, b;
      sel();
      shift(n, tx, rx, a, b);
      desel();
   endtask

   task automatic read_stat(output logic [7:0] v, output logic oe_all);
      logic [23:0] rx; logic a, b;
      sel();
      shift(8, 24'h05, rx, a, b);
      shift(8, 24'h00, rx, oe_all, b);
      desel();
      v = rx[7:0];
   endtask

   task automatic expect_stat(input string tag, input logic [7:0] exp);
      logic [7:0] v; logic oe;
      read_stat(v, oe);
      check(v == exp && oe, tag, {23'd0, oe, v}, {24'd1, exp});
   endtask

   task automatic t_reset();
      check(so_oe == 1'b0, "R1 reset oe", so_oe, 0);
      check(nv_wr_start == 1'b0, "R1 reset strobe", nv_wr_start, 0);
      expect_stat("R1 R4 reset status", 8'h00);
   endtask

   task automatic t_deselected();
      logic seen = 1'b0;
      for (int i = 7; i >= 0; i--) begin
         si = i[0] ^ i[1];
         wait_clks(HALF); seen = seen | so_oe;
         sck = 1'b1; wait_clks(HALF); sck = 1'b0;
      end
      check(!seen, "R1 oe while deselected", seen, 0);
      expect_stat("R1 deselected clocks ignored", 8'h00);
   endtask

   task automatic t_latch();
      send(8, 24'h06);
      expect_stat("R3 write enable sets latch", 8'h02);
      send(8, 24'h04);
      expect_stat("R3 write disable clears latch", 8'h00);
   endtask

   task automatic t_write_no_latch();
      int s0 = starts;
      send(16, 24'h01FF);
      expect_stat("R6 write without latch", 8'h00);
      check(starts == s0, "R6 no strobe", starts - s0, 0);
   endtask

   task automatic t_write_ok();
      int s0 = starts;
      send(8, 24'h06);
      send(16, 24'h01FF);
      check(starts == s0 + 1, "R5 one strobe", starts - s0, 1);
      check(last_wr == 8'h8C, "R5 strobe data masked", last_wr, 8'h8C);
      expect_stat("R5 R2 masked commit and latch cleared", 8'h8C);
   endtask

   task automatic t_bit_count();
      int s0 = starts;
      send(8, 24'h06);
      send(17, 24'h01FF << 1);
      expect_stat("R6 seventeen clocks no commit", 8'h8E);
      check(starts == s0, "R6 no strobe on long write", starts - s0, 0);
      send(8, 24'h04);
      send(9, 24'h06 << 1);
      expect_stat("R6 nine-clock enable ignored", 8'h8C);
   endtask

   task automatic t_repeat();
      logic [23:0] rx; logic oa, ox;
      sel();
      shift(8, 24'h05, rx, oa, ox);
      shift(24, 24'h0, rx, oa, ox);
      desel();
      check(rx == 24'h8C8C8C && oa, "R4 repeated status", rx, 24'h8C8C8C);
   endtask

   task automatic t_invalid();
      logic [23:0] rx; logic oa, ox;
      sel();
      shift(8, 24'hAB, rx, oa, ox);
      shift(16, 24'h0500, rx, oa, ox);
      desel();
      check(!ox, "R7 oe stays low after unknown command", ox, 0);
      sel();
      shift(8, 24'hFF, rx, oa, ox);
      shift(8, 24'h06, rx, oa, ox);
      desel();
      expect_stat("R7 later bits ignored", 8'h8C);
   endtask

   task automatic t_wp_gate();
      logic [23:0] rx; logic oa, ox;
      int s0 = starts;
      wp_n = 1'b0;
      send(8, 24'h06);
      send(16, 24'h0100);
      expect_stat("R9 protected write aborted latch kept", 8'h8E);
      wp_n = 1'b1;
      sel();
      shift(8, 24'h01, rx, oa, ox);
      wp_n = 1'b0; wait_clks(HALF); wp_n = 1'b1;
      shift(8, 24'h00, rx, oa, ox);
      desel();
      expect_stat("R9 short protect pulse aborts", 8'h8E);
      check(starts == s0, "R9 no strobe", starts - s0, 0);
   endtask

   task automatic t_wp_after_commit();
      logic [23:0] rx; logic oa, ox;
      int s0 = starts;
      sel();
      shift(16, 24'h0104, rx, oa, ox);
      wait_clks(HALF);
      cs_n = 1'b1;
      wait_clks(6);
      wp_n = 1'b0;
      wait_clks(4 * HALF);
      check(starts == s0 + 1 && last_wr == 8'h04, "R11 commit survives late protect",
            last_wr, 8'h04);
      expect_stat("R11 status after late protect", 8'h04);
   endtask

   task automatic t_wpen_off();
      send(8, 24'h06);
      send(16, 24'h0108);
      expect_stat("R10 protect pin ignored when disabled", 8'h08);
      wp_n = 1'b1;
   endtask

   task automatic t_hold_read();
      logic [23:0] rx1, rx2; logic oa1, oa2, ox;
      logic seen = 1'b0;
      sel();
      shift(8, 24'h05, rx1, oa1, ox);
      shift(3, 24'h0, rx1, oa1, ox);
      hold_n = 1'b0;
      wait_clks(HALF);
      for (int i = 0; i < 4; i++) begin
         si = 1'b1;
         seen = seen | so_oe;
         sck = 1'b1; wait_clks(HALF);
         seen = seen | so_oe;
         sck = 1'b0; wait_clks(HALF);
      end
      hold_n = 1'b1;
      shift(5, 24'h0, rx2, oa2, ox);
      desel();
      check(!seen, "R8 oe low during pause", seen, 0);
      check({rx1[2:0], rx2[4:0]} == 8'h08 && oa1 && oa2, "R8 read resumes in place",
            {rx1[2:0], rx2[4:0]}, 8'h08);
   endtask

   task automatic t_hold_cmd();
      logic [23:0] rx; logic oa, ox;
      sel();
      shift(3, 24'h0, rx, oa, ox);
      hold_n = 1'b0;
      wait_clks(HALF);
      for (int i = 0; i < 3; i++) begin
         si = 1'b1;
         sck = 1'b1; wait_clks(HALF);
         sck = 1'b0; wait_clks(HALF);
      end
      hold_n = 1'b1;
      shift(5, 24'h06, rx, oa, ox);
      desel();
      expect_stat("R8 paused enable command still counts 8", 8'h0A);
   endtask

   task automatic t_busy();
      nv_busy = 1'b1;
      expect_stat("R12 busy bit", 8'h0B);
      nv_busy = 1'b0;
      expect_stat("R12 busy bit clear", 8'h0A);
   endtask

   initial begin
      wait_clks(5);
      rst_n = 1'b1;
      wait_clks(5);
      t_reset();
      t_deselected();
      t_latch();
      t_write_no_latch();
      t_write_ok();
      t_bit_count();
      t_repeat();
      t_invalid();
      t_wp_gate();
      t_wp_after_commit();
      t_wpen_off();
      t_hold_read();
      t_hold_cmd();
      t_busy();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
   end

   initial begin
      repeat (WD) @(posedge clk);
      if (!done) begin
         nchk++;
         nfail++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
         $finish;
      end
   end

endmodule